// File: doc/BRIEF.md
# Multi-Waveform Direct Digital Synthesis Generator

This block turns a reference clock and a programmable tuning word into a stream of unsigned amplitude samples for an external digital-to-analog converter. A phase register of `PHASE_W` bits advances by the tuning word on every clock and wraps modulo 2^`PHASE_W`. The output frequency is therefore the tuning word times the clock rate divided by 2^`PHASE_W`. The most significant phase bits then pick one sample from one of five shapes.

Two of the shapes come from tables, both addressed by the top `ADDR_W` phase bits. One is a fixed sine table, filled when the design is elaborated. The other is a table that can be written at run time to hold any shape. The triangle, sawtooth and square shapes are formed from the phase bits by plain logic. A shape code picks the source. A change of code takes effect on the next sample and leaves the phase untouched. The selected value is captured in one output register.

Top module: `dds_wavegen`

## Requirements
- R1: On each rising clock edge with `rst` low, the phase register becomes (phase + `tune_word`) mod 2^`PHASE_W`. A clock edge with `rst` high clears the phase and the `sample` output to zero.
- R2: With `PHASE_W`=4 and a tuning word of 1, the phase passes through exactly 16 distinct states before it repeats. The sawtooth output shows all 16 of them.
- R3: The output repeats every 2^`PHASE_W`/K samples for a tuning word K. With `PHASE_W`=4 and K=2, a sample equals the one 8 samples earlier and differs from the one 4 samples earlier.
- R4: Shape code 0 (sine) uses a = top `ADDR_W` phase bits, H = 2^(`ADDR_W`-1), x = a mod H, M = 2^(`SAMPLE_W`-1) and p = floor(4·x·(H−x)·(M−1)/H²). It outputs M+p when a < H and M−p otherwise.
- R5: Shape code 1 (triangle) takes the phase bits just below the MSB, `SAMPLE_W`-1 bits wide. It inverts them when the phase MSB is 1 and outputs them shifted left by one, so bit 0 is always 0.
- R6: Shape code 2 (sawtooth) outputs the top `SAMPLE_W` phase bits.
- R7: Shape code 3 (square) outputs all ones when the phase MSB is 0 and all zeros when it is 1.
- R8: Shape code 4 outputs the writable table entry at the top `ADDR_W` phase bits. A write (`tbl_we` high at a clock edge) is accepted at any time, including during reset. It is seen from the next clock edge onward. A read at the same edge as the write returns the old entry.
- R9: Codes 5 to 7 output mid-scale, 2^(`SAMPLE_W`-1). A change of code alters only the shape and never the phase sequence.
- R10: The `sample` output at an edge reflects the phase and shape code present just before that edge (one register of latency).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| tune_word | input | PHASE_W | Phase increment per clock |
| wave_sel | input | 3 | Shape code (0 sine, 1 triangle, 2 sawtooth, 3 square, 4 user table) |
| tbl_we | input | 1 | User table write enable |
| tbl_waddr | input | ADDR_W | User table write address |
| tbl_wdata | input | SAMPLE_W | User table write data |
| sample | output | SAMPLE_W | Registered amplitude sample, unsigned offset-binary |

## Verification
The bench builds two copies side by side. The first is wide, with a 32-bit phase, a 256-entry table and 12-bit samples. It exercises long tuning words, phase bits that are discarded, and the parabolic sine shape at realistic resolution. The second is tiny, with a 4-bit phase, a 16-entry table and 4-bit samples. In it the whole phase circle has only 16 states, so the bench can walk every state, measure repetition periods exactly, and reach write-then-read collisions on the same table address within a few cycles.

// File: rtl/dds_pkg.sv
package dds_pkg;

    typedef enum logic [2:0] {
        WAVE_SINE   = 3'd0,
        WAVE_TRI    = 3'd1,
        WAVE_SAW    = 3'd2,
        WAVE_SQUARE = 3'd3,
        WAVE_USER   = 3'd4
    } wave_e;

    // Parabolic half-cycle approximation of a sine, offset-binary.
    function automatic int sine_point(input int idx, input int aw, input int sw);
        int half;
        int x;
        int mid;
        int p;
        half = 1 << (aw - 1);
        x    = idx % half;
        mid  = 1 << (sw - 1);
        p    = (4 * x * (half - x) * (mid - 1)) / (half * half);
        return (idx < half) ? (mid + p) : (mid - p);
    endfunction

endpackage

// File: rtl/dds_phase_acc.sv
module dds_phase_acc #(
    parameter int PHASE_W = 32,
    parameter int TOP_W   = 12
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [PHASE_W-1:0] tune_word,
    output logic [TOP_W-1:0]   phase_top
);
    logic [PHASE_W-1:0] phase_q;

    always_ff @(posedge clk) begin
        if (rst) phase_q <= '0;
        else     phase_q <= phase_q + tune_word;
    end

    assign phase_top = phase_q[PHASE_W-1 -: TOP_W];

    AST_PHASE_STEP: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> phase_q == $past(phase_q) + $past(tune_word)); // R1
endmodule

// File: rtl/dds_sine_rom.sv
module dds_sine_rom
    import dds_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int SAMPLE_W = 12
) (
    input  logic [ADDR_W-1:0]   addr,
    output logic [SAMPLE_W-1:0] dout
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [SAMPLE_W-1:0] table_c [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_entry
        assign table_c[i] = SAMPLE_W'(sine_point(i, ADDR_W, SAMPLE_W));
    end

    assign dout = table_c[addr];
endmodule

// File: rtl/dds_user_ram.sv
module dds_user_ram #(
    parameter int ADDR_W   = 8,
    parameter int SAMPLE_W = 12
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                we,
    input  logic [ADDR_W-1:0]   waddr,
    input  logic [SAMPLE_W-1:0] wdata,
    input  logic [ADDR_W-1:0]   raddr,
    output logic [SAMPLE_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [SAMPLE_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];

    AST_USER_STORE: assert property (@(posedge clk) disable iff (rst)
        we |=> mem[$past(waddr)] == $past(wdata)); // R8
endmodule

// File: rtl/dds_shape_logic.sv
module dds_shape_logic #(
    parameter int SAMPLE_W = 12
) (
    input  logic [SAMPLE_W-1:0] phase_hi,
    output logic [SAMPLE_W-1:0] tri_o,
    output logic [SAMPLE_W-1:0] saw_o,
    output logic [SAMPLE_W-1:0] sq_o
);
    logic                msb;
    logic [SAMPLE_W-2:0] ramp;

    assign msb   = phase_hi[SAMPLE_W-1];
    assign ramp  = msb ? ~phase_hi[SAMPLE_W-2:0] : phase_hi[SAMPLE_W-2:0];
    assign tri_o = {ramp, 1'b0};
    assign saw_o = phase_hi;
    assign sq_o  = msb ? '0 : '1;
endmodule

// File: rtl/dds_wavegen.sv
module dds_wavegen
    import dds_pkg::*;
#(
    parameter int PHASE_W  = 32,
    parameter int ADDR_W   = 8,
    parameter int SAMPLE_W = 12
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [PHASE_W-1:0]  tune_word,
    input  logic [2:0]          wave_sel,
    input  logic                tbl_we,
    input  logic [ADDR_W-1:0]   tbl_waddr,
    input  logic [SAMPLE_W-1:0] tbl_wdata,
    output logic [SAMPLE_W-1:0] sample
);
    localparam int TOP_W = (ADDR_W > SAMPLE_W) ? ADDR_W : SAMPLE_W;
    localparam logic [SAMPLE_W-1:0] MID = SAMPLE_W'(1) << (SAMPLE_W - 1);

    logic [TOP_W-1:0]    phase_top;
    logic [ADDR_W-1:0]   rd_addr;
    logic [SAMPLE_W-1:0] sine_v, user_v, tri_v, saw_v, sq_v, pick;

    dds_phase_acc #(.PHASE_W(PHASE_W), .TOP_W(TOP_W)) u_acc (
        .clk(clk), .rst(rst), .tune_word(tune_word), .phase_top(phase_top)
    );

    assign rd_addr = phase_top[TOP_W-1 -: ADDR_W];

    dds_sine_rom #(.ADDR_W(ADDR_W), .SAMPLE_W(SAMPLE_W)) u_sine (
        .addr(rd_addr), .dout(sine_v)
    );

    dds_user_ram #(.ADDR_W(ADDR_W), .SAMPLE_W(SAMPLE_W)) u_user (
        .clk(clk), .rst(rst), .we(tbl_we), .waddr(tbl_waddr), .wdata(tbl_wdata),
        .raddr(rd_addr), .rdata(user_v)
    );

    dds_shape_logic #(.SAMPLE_W(SAMPLE_W)) u_shape (
        .phase_hi(phase_top[TOP_W-1 -: SAMPLE_W]),
        .tri_o(tri_v), .saw_o(saw_v), .sq_o(sq_v)
    );

    always_comb begin
        case (wave_e'(wave_sel))
            WAVE_SINE:   pick = sine_v;
            WAVE_TRI:    pick = tri_v;
            WAVE_SAW:    pick = saw_v;
            WAVE_SQUARE: pick = sq_v;
            WAVE_USER:   pick = user_v;
            default:     pick = MID;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) sample <= '0;
        else     sample <= pick;
    end

    AST_SQUARE_RAIL: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(wave_sel) == 3'd3) |-> (sample == '0 || sample == '1)); // R7
    AST_TRI_EVEN: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(wave_sel) == 3'd1) |-> sample[0] == 1'b0); // R5
    AST_RESERVED_MID: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(wave_sel) >= 3'd5) |-> sample == MID); // R9
endmodule

// File: tb/dds_wavegen_tb.sv
module dds_wavegen_tb_top;
    localparam int BN = 32, BA = 8, BW = 12;
    localparam int SN = 4,  SA = 4, SW = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [BN-1:0] k_b = '0;
    logic [SN-1:0] k_s = '0;
    logic [2:0]    sel = 3'd2;
    logic          we = 1'b0;
    logic [BA-1:0] wa_b = '0;
    logic [BW-1:0] wd_b = '0;
    logic [SA-1:0] wa_s = '0;
    logic [SW-1:0] wd_s = '0;
    logic [BW-1:0] out_b;
    logic [SW-1:0] out_s;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    longint unsigned ph_b = 0, ph_s = 0;
    longint unsigned arb_b [256];
    longint unsigned arb_s [16];
    longint unsigned exp_b, exp_s;

    always #10 clk = ~clk;

    dds_wavegen #(.PHASE_W(BN), .ADDR_W(BA), .SAMPLE_W(BW)) dut_i (
        .clk(clk), .rst(rst), .tune_word(k_b), .wave_sel(sel), .tbl_we(we),
        .tbl_waddr(wa_b), .tbl_wdata(wd_b), .sample(out_b)
    );

    dds_wavegen #(.PHASE_W(SN), .ADDR_W(SA), .SAMPLE_W(SW)) dut_small (
        .clk(clk), .rst(rst), .tune_word(k_s), .wave_sel(sel), .tbl_we(we),
        .tbl_waddr(wa_s), .tbl_wdata(wd_s), .sample(out_s)
    );

    function automatic longint unsigned sine_ref(longint unsigned a, int aw, int sw);
        longint unsigned h, x, m, p;
        h = 64'd1 << (aw - 1);
        x = a % h;
        m = 64'd1 << (sw - 1);
        p = (4 * x * (h - x) * (m - 1)) / (h * h);
        return (a < h) ? m + p : m - p;
    endfunction

    function automatic longint unsigned model(int n, int aw, int sw, longint unsigned ph,
                                              int s, longint unsigned userv);
        longint unsigned a, top, msb, low, lmask;
        a     = ph >> (n - aw);
        top   = ph >> (n - sw);
        msb   = (ph >> (n - 1)) & 1;
        lmask = (64'd1 << (sw - 1)) - 1;
        case (s)
            0: return sine_ref(a, aw, sw);
            1: begin
                low = top & lmask;
                if (msb != 0) low = ~low & lmask;
                return low << 1;
            end
            2: return top;
            3: return (msb != 0) ? 0 : (64'd1 << sw) - 1;
            4: return userv;
            default: return 64'd1 << (sw - 1);
        endcase
    endfunction

    function automatic string tag_of(int s);
        case (s)
            0: return "R4";
            1: return "R5";
            2: return "R6";
            3: return "R7";
            4: return "R8";
            default: return "R9";
        endcase
    endfunction

    task automatic check(string req, longint unsigned act, longint unsigned expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    // One cycle: drive at negedge, predict, let the edge pass, compare (R1, R10).
    task automatic step(longint unsigned kb, longint unsigned ks, int s, bit w,
                        int ab, longint unsigned db, int as_, longint unsigned ds);
        k_b = BN'(kb); k_s = SN'(ks); sel = 3'(s); we = w;
        wa_b = BA'(ab); wd_b = BW'(db); wa_s = SA'(as_); wd_s = SW'(ds);
        exp_b = model(BN, BA, BW, ph_b, s, arb_b[ph_b >> (BN - BA)]);
        exp_s = model(SN, SA, SW, ph_s, s, arb_s[ph_s >> (SN - SA)]);
        ph_b = (ph_b + kb) & 64'hFFFF_FFFF;
        ph_s = (ph_s + ks) & 64'hF;
        if (w) begin
            arb_b[ab] = db;
            arb_s[as_] = ds;
        end
        @(posedge clk);
        @(negedge clk);
        check({tag_of(s), " wide"}, out_b, exp_b);
        check({tag_of(s), " small"}, out_s, exp_s);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        we = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        check("R1 reset wide", out_b, 0);
        check("R1 reset small", out_s, 0);
        rst = 1'b0;
        ph_b = 0;
        ph_s = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int unsigned seed;
        longint unsigned seen;
        longint unsigned hist [16];
        seed = $urandom(32'h5EED_1234);
        @(negedge clk);
        do_reset();

        // Load both user tables while watching the sawtooth (R6, R8).
        for (int i = 0; i < 256; i++) begin
            step($urandom, $urandom, 2, 1'b1, i, $urandom & 12'hFFF, i % 16, $urandom & 4'hF);
        end

        // R2: tiny phase visits all 16 states with K=1.
        do_reset();
        seen = 0;
        for (int i = 0; i < 16; i++) begin
            step(64'd1, 64'd1, 2, 1'b0, 0, 0, 0, 0);
            seen = seen | (64'd1 << out_s);
        end
        check("R2 distinct states", $countones(seen), 16);
        step(64'd1, 64'd1, 2, 1'b0, 0, 0, 0, 0);
        check("R2 wrap to zero", out_s, 0);

        // R3: K=2 gives a period of 8 samples.
        for (int i = 0; i < 16; i++) begin
            step(64'd3, 64'd2, 2, 1'b0, 0, 0, 0, 0);
            hist[i] = out_s;
        end
        check("R3 period 8", hist[15], hist[7]);
        checks++;
        if (hist[15] == hist[11]) begin
            errors++;
            $display("FAIL R3: actual %0d equals half-period sample, expected different", hist[15]);
        end

        // Directed pass over every shape code, including reserved ones (R4..R9).
        for (int s = 0; s < 8; s++) begin
            for (int i = 0; i < 20; i++) begin
                step(64'h0123_4567, 64'd3, s, 1'b0, 0, 0, 0, 0);
            end
        end

        // R8: write the address being read; old value first, new value after.
        step(64'd0, 64'd0, 4, 1'b1, int'(ph_b >> (BN - BA)), 12'hABC,
             int'(ph_s), (arb_s[ph_s] + 1) & 4'hF);
        step(64'd0, 64'd0, 4, 1'b0, 0, 0, 0, 0);
        check("R8 new entry visible wide", out_b, 12'hABC);

        // Mid-run reset (R1).
        do_reset();

        // Constrained random mix (R1, R9, R10 and all shapes).
        for (int i = 0; i < 4000; i++) begin
            step({$urandom, $urandom} & 64'hFFFF_FFFF, $urandom & 4'hF, $urandom % 8,
                 ($urandom % 4) == 0, $urandom % 256, $urandom & 12'hFFF,
                 $urandom % 16, $urandom & 4'hF);
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule